// File: doc/BRIEF.md
# Predicated Non-Faulting Halfword Vector Load Sequencer

This block fills one vector register from memory, one element at a time, under control of a byte-granular predicate. After a start pulse it works out where the vector begins in memory, then walks the elements in ascending order. For each active element it issues a single 16-bit read on a valid/ready request port and waits for the response. The halfword that comes back is zero-extended into an element lane that is 16, 32 or 64 bits wide. Inactive elements issue no read and are written as zero.

Memory faults never trap. A response that carries the fault flag is discarded and its lane becomes zero. From that element onward, every element's group in the first-fault register (FFR) is cleared. The FFR value supplied at start is carried through, and bits are only ever cleared, never set. Lanes whose FFR entry is already clear follow one fixed policy: they take the loaded halfword if their own access completed, and zero otherwise. When the last element has been handled, the block pulses done. The result vector and the FFR are then held until the next start.

Top module: `nf_hword_loader`

## Requirements
- R1: The first element's address is base + sext(imm) × (VL/8 >> sel), computed modulo 2^64. Here imm is a 4-bit two's complement value (-8..7) and sel is the width code of R3. This holds whatever the predicate is.
- R2: Element e uses address start + 2·e modulo 2^64, active or not. Requests are issued only for active elements, one per element, in ascending element order.
- R3: The width code sel selects the element width: 0 gives 16 bits, 1 gives 32, and 2 or 3 gives 64. There are VL/width elements. Element e occupies result bits [e·width +: width] and holds the halfword zero-extended.
- R4: Element e is active when predicate bit e·(width/8) is 1. All other predicate bits are ignored.
- R5: An inactive element issues no request, never counts as a fault, and its lane is zero.
- R6: A response with the fault flag set has its data discarded, and that lane is zero. The FFR group of that element, bits [e·width/8 +: width/8], is cleared, and so is the group of every later element.
- R7: FFR bits are never set. An element whose FFR entry was already clear, or that follows a cleared entry, still receives its loaded halfword when its own access did not fault.
- R8: done is high for exactly one cycle after the last element. The result and FFR outputs hold their values until the next accepted start.
- R9: A start pulse that arrives while a load is in progress is ignored.
- R10: While a request is pending and req_ready is low, req_valid stays high and req_addr does not change.
- R11: After reset, done and req_valid are low, and the result and FFR outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; sampled only while idle |
| esize_sel | input | 2 | Element width code (R3) |
| imm | input | 4 | Signed vector-count offset |
| base | input | 64 | Scalar base address |
| pred | input | VL/8 | Governing predicate, one bit per byte |
| ffr_in | input | VL/8 | FFR value on entry |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Halfword read address |
| rsp_valid | input | 1 | Memory response valid |
| rsp_data | input | 16 | Response halfword |
| rsp_fault | input | 1 | Response access was suppressed |
| done | output | 1 | One-cycle completion pulse |
| result | output | VL | Assembled destination vector |
| ffr_out | output | VL/8 | Updated FFR |

## Verification
The bench targets several corner cases, each paired with the symptom a faulty design would show:

- Address wrap in both directions: an immediate of -8 from a small base, and a run that crosses 2^64. A design that truncates or sign-handles the offset wrongly issues requests at the wrong place.
- A fault in mid-vector followed by accesses that succeed: these show whether the fault is sticky in the FFR while later lanes still keep their data. A design that is not sticky leaves later FFR bits set; one that is too eager zeroes good lanes.
- A fault address that falls on an inactive element, predicates with stray bits set inside each byte group, and an incoming FFR with holes: these catch a design that reads the wrong predicate bit, or that lets inactive lanes fault.
- A start pulse during a run, and back-pressure on the request port: a design that restarts, or drops or reorders requests, shows up in the recorded address trace.

// File: rtl/nf_hword_loader.sv
module nf_hword_loader #(
  parameter int VL = 256,
  localparam int PB = VL / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    esize_sel,
  input  logic [3:0]    imm,
  input  logic [63:0]   base,
  input  logic [PB-1:0] pred,
  input  logic [PB-1:0] ffr_in,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [63:0]   req_addr,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  input  logic          rsp_fault,
  output logic          done,
  output logic [VL-1:0] result,
  output logic [PB-1:0] ffr_out
);
  localparam int NMAX = VL / 16;
  localparam int IW   = $clog2(NMAX);
  localparam int GW   = $clog2(PB);
  localparam int LW   = $clog2(VL);

  typedef enum logic [1:0] {IDLE, RUN, WAIT} st_t;
  st_t st;

  logic [IW-1:0] idx;
  logic [63:0]   addr_q;
  logic [1:0]    sel_q;
  logic          faulted_q;
  logic [PB-1:0] pred_q;

  logic [1:0]  sel_in;
  logic [63:0] start_addr;
  logic [GW-1:0] gidx;
  logic [LW-1:0] lane_off;
  logic active, last, step, s_fault, faulted_n;
  logic [15:0] s_data;

  assign sel_in     = (esize_sel == 2'd3) ? 2'd2 : esize_sel;
  assign start_addr = base + {{60{imm[3]}}, imm} * (64'(PB) >> sel_in);

  assign gidx     = GW'(idx) << (sel_q + 2'd1);
  assign lane_off = LW'(idx) << (sel_q + 3'd4);
  assign active   = pred_q[gidx];
  assign last     = idx == IW'((NMAX >> sel_q) - 1);

  assign req_valid = (st == RUN) && active;
  assign req_addr  = addr_q;

  assign step    = ((st == RUN) && !active) || ((st == WAIT) && rsp_valid);
  assign s_fault = (st == WAIT) && rsp_fault;
  assign s_data  = ((st == WAIT) && !rsp_fault) ? rsp_data : 16'h0;
  assign faulted_n = faulted_q | s_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      idx       <= '0;
      addr_q    <= '0;
      sel_q     <= '0;
      faulted_q <= 1'b0;
      pred_q    <= '0;
      result    <= '0;
      ffr_out   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st        <= RUN;
          idx       <= '0;
          addr_q    <= start_addr;
          sel_q     <= sel_in;
          faulted_q <= 1'b0;
          pred_q    <= pred;
          result    <= '0;
          ffr_out   <= ffr_in;
        end
        RUN: if (active && req_ready) st <= WAIT;
        default: ;
      endcase
      if (step) begin
        result[lane_off +: 16] <= s_data;
        faulted_q <= faulted_n;
        for (int j = 0; j < PB; j++)
          if (faulted_n && ((j >> (sel_q + 2'd1)) == int'(idx)))
            ffr_out[j] <= 1'b0;
        addr_q <= addr_q + 64'd2;
        idx    <= idx + 1'b1;
        if (last) begin
          st   <= IDLE;
          done <= 1'b1;
        end else begin
          st <= RUN;
        end
      end
    end
  end
endmodule

module nf_hword_loader_chk #(
  parameter int VL = 256,
  localparam int PB = VL / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          req_valid,
  input logic          req_ready,
  input logic [63:0]   req_addr,
  input logic          done,
  input logic [PB-1:0] ffr_out
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);
  // R7
  ffr_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ((ffr_out & ~$past(ffr_out)) == '0));
  // R5
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !req_valid);
endmodule

bind nf_hword_loader nf_hword_loader_chk #(.VL(VL)) chk_i (
  .clk(clk), .rst_n(rst_n), .running(st != IDLE),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .done(done), .ffr_out(ffr_out)
);

// File: tb/nf_hword_loader_tb_top.sv
`timescale 1ns/1ps
module nf_hword_loader_tb_top;
  localparam int VL = 256;
  localparam int PB = VL / 8;

  typedef struct packed {
    logic [1:0]  sel;
    logic [3:0]  imm;
    logic [63:0] base;
    logic [31:0] pred;
    logic [31:0] ffr;
    logic        fen;
    logic [63:0] flo;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'h0, 64'h1000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 64'h0},
    '{2'd1, 4'h1, 64'h2000, 32'h1E1E_F101, 32'hFFFF_FFFF, 1'b0, 64'h0},
    '{2'd2, 4'hF, 64'h3000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 64'h0},
    '{2'd0, 4'h8, 64'h0010, 32'h5555_5555, 32'hFFFF_FFFF, 1'b0, 64'h0},
    '{2'd0, 4'h0, 64'hFFFF_FFFF_FFFF_FFF8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 64'h0},
    '{2'd0, 4'h0, 64'h4000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 64'h4008},
    '{2'd3, 4'h2, 64'h5000, 32'h0101_0101, 32'hFFFF_FFFF, 1'b1, 64'h5048},
    '{2'd0, 4'h0, 64'h6000, 32'hFFFF_FFFF, 32'hFFFF_0FFF, 1'b0, 64'h0},
    '{2'd0, 4'h0, 64'h7000, 32'hFFFF_FFCF, 32'hFFFF_FFFF, 1'b1, 64'h7004}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] esize_sel = '0;
  logic [3:0] imm = '0;
  logic [63:0] base = '0;
  logic [PB-1:0] pred = '0, ffr_in = '0;
  logic req_valid, req_ready = 1'b1;
  logic [63:0] req_addr;
  logic rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [15:0] rsp_data = '0;
  logic done;
  logic [VL-1:0] result;
  logic [PB-1:0] ffr_out;

  always #4 clk = ~clk;

  nf_hword_loader #(.VL(VL)) dut_i (.*);

  int total = 0, bad = 0;
  logic fen_cur = 1'b0, stall_en = 1'b0, clr_seen = 1'b0;
  logic [63:0] flo_cur = '0;
  logic [63:0] seen [16];
  int nseen = 0, rdy_cnt = 0;

  logic [VL-1:0] exp_res;
  logic [PB-1:0] exp_ffr;
  logic [63:0]   exp_adr [16];
  int            exp_n;

  function automatic logic [15:0] dat(input logic [63:0] a);
    return a[16:1] ^ a[32:17] ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    if (clr_seen) nseen <= 0;
    if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= dat(req_addr);
      rsp_fault <= fen_cur && (req_addr == flo_cur);
      if (nseen < 16) seen[nseen] <= req_addr;
      nseen <= nseen + 1;
    end else begin
      rsp_valid <= 1'b0;
      rsp_data  <= 16'hDEAD;
      rsp_fault <= 1'b0;
    end
  end

  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    req_ready <= !stall_en || (rdy_cnt % 3 == 0);
  end

  task automatic chk(input bit ok, input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input vec_t v);
    int s, eb, ne, w;
    logic [63:0] st, ad;
    logic faulted, flt;
    s = (v.sel == 2'd3) ? 2 : int'(v.sel);
    eb = 2 << s; ne = 16 >> s; w = 16 << s;
    st = v.base + {{60{v.imm[3]}}, v.imm} * 64'(32 >> s);
    faulted = 1'b0; exp_res = '0; exp_ffr = v.ffr; exp_n = 0;
    for (int e = 0; e < ne; e++) begin
      ad = st + 64'(2 * e);
      flt = 1'b0;
      if (v.pred[e * eb]) begin
        exp_adr[exp_n] = ad;
        exp_n++;
        flt = v.fen && (ad == v.flo);
        exp_res[e * w +: 16] = flt ? 16'h0 : dat(ad);
      end
      faulted = faulted | flt;
      if (faulted) for (int j = 0; j < eb; j++) exp_ffr[e * eb + j] = 1'b0;
    end
  endtask

  task automatic drive(input vec_t v);
    esize_sel = v.sel; imm = v.imm; base = v.base;
    pred = v.pred; ffr_in = v.ffr;
  endtask

  task automatic run(input vec_t v, input bit stall, input bit restart, input string tag);
    int cnt;
    bit adr_ok;
    model(v);
    @(negedge clk);
    drive(v);
    fen_cur = v.fen; flo_cur = v.flo; stall_en = stall;
    clr_seen = 1'b1; start = 1'b1;
    @(negedge clk);
    clr_seen = 1'b0; start = 1'b0;
    cnt = 0;
    while (!done && cnt < 1000) begin
      if (restart && cnt == 3) begin
        drive(VECS[2]); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(done === 1'b1, {tag, " R8 done seen"}, VL'(done), VL'(1));
    chk(result === exp_res, {tag, " R3 R5 R6 R7 result"}, result, exp_res);
    chk(ffr_out === exp_ffr, {tag, " R6 R7 ffr"}, VL'(ffr_out), VL'(exp_ffr));
    chk(nseen == exp_n, {tag, " R2 R4 R5 request count"}, VL'(nseen), VL'(exp_n));
    adr_ok = 1'b1;
    for (int k = 0; k < exp_n && k < 16; k++)
      if (seen[k] !== exp_adr[k]) adr_ok = 1'b0;
    chk(adr_ok, {tag, " R1 R2 R10 address trace"},
        VL'((nseen > 0) ? seen[0] : 64'h0), VL'((exp_n > 0) ? exp_adr[0] : 64'h0));
    @(negedge clk);
    chk(done === 1'b0 && result === exp_res && ffr_out === exp_ffr,
        {tag, " R8 pulse and hold"}, VL'(done), VL'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(done === 1'b0 && req_valid === 1'b0, "R11 control idle", VL'({done, req_valid}), VL'(0));
    chk(result === '0 && ffr_out === '0, "R11 outputs zero", result, '0);

    for (int i = 0; i < NV; i++)
      run(VECS[i], i % 2 == 1, 1'b0, $sformatf("vec%0d", i));

    // R9 start while busy is ignored
    run(VECS[0], 1'b1, 1'b1, "restart R9");
    // R10 heavy stall on a wrapping run
    run(VECS[4], 1'b1, 1'b0, "stall R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule